// File: doc/BRIEF.md
# Bidirectional Host-to-MCU Mailbox Bridge

This block passes short messages between a slow 8-bit legacy processor bus (the host) and a local microcontroller (the MCU). Both sides share one fast system clock. The host read and write strobes are asynchronous and active-low, and each host access spans several system clocks. The block synchronizes both strobes and acts once per access, when the strobe is released.

In the inbound direction, every host write is stored as one 12-bit word. The upper four bits hold the register index the host selected and the lower eight bits hold the byte it wrote. A two-entry buffer keeps these words and raises an interrupt to the MCU. The MCU takes words with a one-cycle read pulse. If the host writes while both entries are full, the write is dropped and a sticky overrun flag is set.

In the outbound direction, the MCU writes a byte into a two-stage buffer. This raises an interrupt to the host. Each host read drains one stage, and the interrupt clears once both stages are empty.

Top module: `mailbox_bridge`

## Requirements
- R1: While `rst` is high, and on the cycle after it, `mcu_irq`, `host_irq` and `mcu_overrun` are all 0.
- R2: A host write stores `{host_addr, host_wdata}` as one word: index in bits [11:8], byte in bits [7:0]. The word appears on `mcu_word` with `mcu_irq` at 1 no later than 3 clocks after `host_wr_n` rises. A write strobe held low for any number of clocks stores exactly one word.
- R3: A second host write, made while the first word is unread, is held. After `mcu_rd` the second word appears on `mcu_word` and `mcu_irq` stays at 1.
- R4: `mcu_rd` with a single word held clears `mcu_irq`. `mcu_rd` while nothing is held has no effect: a later host write is the only word then presented.
- R5: A host write made while both inbound entries are full is dropped, and the two held words come out unchanged and in order. The write sets `mcu_overrun`, which stays at 1 until reset.
- R6: An MCU write (`mcu_wr` high for one clock) makes `host_irq` 1 on the next clock and presents the byte on `host_rdata`.
- R7: A host read presents the oldest outbound byte on `host_rdata` while `host_rd_n` is low. Its completion drains that byte. If only one stage was held, `host_irq` clears within 3 clocks of the rise of `host_rd_n`.
- R8: A second MCU write, made before the host has read, is held in the second stage. `host_irq` stays at 1 until both bytes have been read, and the bytes come out in write order. An MCU write made while both stages are full is dropped.
- R9: A host read while the outbound buffer is empty has no effect: `host_irq` stays at 0 and the next MCU write is read back intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 4 | Register index of a host write |
| host_wdata | input | 8 | Byte of a host write |
| host_wr_n | input | 1 | Asynchronous active-low host write strobe |
| host_rd_n | input | 1 | Asynchronous active-low host read strobe |
| host_rdata | output | 8 | Oldest outbound byte |
| host_irq | output | 1 | Interrupt to the host, high while an outbound byte waits |
| mcu_rd | input | 1 | One-clock pulse that takes the oldest inbound word |
| mcu_word | output | 12 | Oldest inbound word, index in [11:8], byte in [7:0] |
| mcu_irq | output | 1 | Interrupt to the MCU, high while an inbound word waits |
| mcu_overrun | output | 1 | Sticky flag: a host write was dropped |
| mcu_wr | input | 1 | One-clock pulse that loads an outbound byte |
| mcu_wdata | input | 8 | Outbound byte |

## Verification
The assertions assume a few things about the inputs:
- The MCU-side pulses `mcu_rd` and `mcu_wr` are synchronous to `clk`.
- The host keeps `host_addr` and `host_wdata` stable from the fall of `host_wr_n` until at least three clocks after it rises.
- The host never drives both strobes low at the same time.

The stimulus stays within these limits. It changes the host address, data and strobes only on falling clock edges. It holds each host strobe low for between 3 and 20 clocks, and waits five clocks after each strobe rises before changing anything else. It issues MCU pulses one at a time and only between host accesses.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  // Operation applied to a two-entry buffer in one clock: {push, pop}.
  typedef enum logic [1:0] {
    OP_IDLE = 2'b00,
    OP_POP  = 2'b01,
    OP_PUSH = 2'b10,
    OP_BOTH = 2'b11
  } buf_op_e;
endpackage

// File: rtl/mbx_strobe_sync.sv
module mbx_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic strobe_n,
  output logic done
);
  localparam int MSB = STAGES - 1;

  logic [MSB:0] shreg;
  logic         last_q;

  generate
    if (STAGES > 1) begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) shreg <= '1;
        else     shreg <= {shreg[MSB-1:0], strobe_n};
      end
    end else begin : g_single
      always_ff @(posedge clk) begin
        if (rst) shreg <= '1;
        else     shreg <= strobe_n;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b1;
    else     last_q <= shreg[MSB];
  end

  // Release of the active-low strobe: one pulse per access.
  assign done = shreg[MSB] & ~last_q;
endmodule

// File: rtl/mbx_dbuf.sv
module mbx_dbuf
  import mbx_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic             valid,
  output logic             drop
);
  logic [WIDTH-1:0] head_q, tail_q;
  logic             head_v, tail_v;
  logic             pop_ok;
  buf_op_e          op;

  assign pop_ok = pop & head_v;
  assign op     = buf_op_e'({push, pop_ok});
  assign drop   = push & head_v & tail_v & ~pop_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      head_v <= 1'b0;
      tail_v <= 1'b0;
    end else begin
      unique case (op)
        OP_PUSH: begin
          if (!head_v)      head_v <= 1'b1;
          else if (!tail_v) tail_v <= 1'b1;
        end
        OP_POP: begin
          head_v <= tail_v;
          tail_v <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    unique case (op)
      OP_PUSH: begin
        if (!head_v)      head_q <= din;
        else if (!tail_v) tail_q <= din;
      end
      OP_POP:  head_q <= tail_q;
      OP_BOTH: begin
        if (tail_v) begin
          head_q <= tail_q;
          tail_q <= din;
        end else begin
          head_q <= din;
        end
      end
      default: ;
    endcase
  end

  assign dout  = head_q;
  assign valid = head_v;
endmodule

// File: rtl/mailbox_bridge.sv
module mailbox_bridge #(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ADDR_W-1:0]        host_addr,
  input  logic [DATA_W-1:0]        host_wdata,
  input  logic                     host_wr_n,
  input  logic                     host_rd_n,
  output logic [DATA_W-1:0]        host_rdata,
  output logic                     host_irq,
  input  logic                     mcu_rd,
  output logic [ADDR_W+DATA_W-1:0] mcu_word,
  output logic                     mcu_irq,
  output logic                     mcu_overrun,
  input  logic                     mcu_wr,
  input  logic [DATA_W-1:0]        mcu_wdata
);
  localparam int WORD_W = ADDR_W + DATA_W;

  logic wr_done, rd_done;
  logic in_drop, out_drop_unused;
  logic ovr_q;

  mbx_strobe_sync #(.STAGES(SYNC_STAGES)) u_wr_sync (
    .clk(clk), .rst(rst), .strobe_n(host_wr_n), .done(wr_done)
  );

  mbx_strobe_sync #(.STAGES(SYNC_STAGES)) u_rd_sync (
    .clk(clk), .rst(rst), .strobe_n(host_rd_n), .done(rd_done)
  );

  mbx_dbuf #(.WIDTH(WORD_W)) u_inbound (
    .clk(clk), .rst(rst),
    .push(wr_done), .pop(mcu_rd),
    .din({host_addr, host_wdata}),
    .dout(mcu_word), .valid(mcu_irq), .drop(in_drop)
  );

  mbx_dbuf #(.WIDTH(DATA_W)) u_outbound (
    .clk(clk), .rst(rst),
    .push(mcu_wr), .pop(rd_done),
    .din(mcu_wdata),
    .dout(host_rdata), .valid(host_irq), .drop(out_drop_unused)
  );

  always_ff @(posedge clk) begin
    if (rst)          ovr_q <= 1'b0;
    else if (in_drop) ovr_q <= 1'b1;
  end

  assign mcu_overrun = ovr_q;
endmodule

// File: rtl/mailbox_bridge_chk.sv
module mailbox_bridge_chk #(
  parameter int WORD_W = 12,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_done,
  input logic              rd_done,
  input logic              mcu_rd,
  input logic              mcu_wr,
  input logic              mcu_irq,
  input logic              host_irq,
  input logic              mcu_overrun,
  input logic [WORD_W-1:0] mcu_word,
  input logic [DATA_W-1:0] host_rdata
);
  // R1
  p_reset_clears_r1: assert property (@(posedge clk)
    rst |=> (!mcu_irq && !host_irq && !mcu_overrun));

  // R2
  p_write_sets_irq_r2: assert property (@(posedge clk) disable iff (rst)
    wr_done |=> mcu_irq);

  // R3
  p_word_held_r3: assert property (@(posedge clk) disable iff (rst)
    (mcu_irq && !mcu_rd) |=> ($stable(mcu_word) && mcu_irq));

  // R4
  p_irq_fall_needs_rd_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(mcu_irq) |-> $past(mcu_rd));

  // R5
  p_overrun_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    mcu_overrun |=> mcu_overrun);

  // R5
  p_overrun_cause_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(mcu_overrun) |-> $past(wr_done && mcu_irq));

  // R6
  p_mcu_wr_irq_r6: assert property (@(posedge clk) disable iff (rst)
    mcu_wr |=> host_irq);

  // R7
  p_host_irq_fall_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(host_irq) |-> $past(rd_done));

  // R8
  p_rdata_held_r8: assert property (@(posedge clk) disable iff (rst)
    (host_irq && !rd_done) |=> ($stable(host_rdata) && host_irq));

  // R2
  p_strobes_exclusive_r2: assert property (@(posedge clk) disable iff (rst)
    !(wr_done && rd_done));
endmodule

bind mailbox_bridge mailbox_bridge_chk #(
  .WORD_W(ADDR_W + DATA_W),
  .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst(rst), .wr_done(wr_done), .rd_done(rd_done),
  .mcu_rd(mcu_rd), .mcu_wr(mcu_wr), .mcu_irq(mcu_irq), .host_irq(host_irq),
  .mcu_overrun(mcu_overrun), .mcu_word(mcu_word), .host_rdata(host_rdata)
);

// File: tb/mailbox_bridge_bench.sv
module mailbox_bridge_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  host_addr = '0;
  logic [7:0]  host_wdata = '0;
  logic        host_wr_n = 1'b1;
  logic        host_rd_n = 1'b1;
  logic [7:0]  host_rdata;
  logic        host_irq;
  logic        mcu_rd = 1'b0;
  logic [11:0] mcu_word;
  logic        mcu_irq;
  logic        mcu_overrun;
  logic        mcu_wr = 1'b0;
  logic [7:0]  mcu_wdata = '0;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  mailbox_bridge u_mailbox_bridge (
    .clk(clk), .rst(rst),
    .host_addr(host_addr), .host_wdata(host_wdata),
    .host_wr_n(host_wr_n), .host_rd_n(host_rd_n),
    .host_rdata(host_rdata), .host_irq(host_irq),
    .mcu_rd(mcu_rd), .mcu_word(mcu_word), .mcu_irq(mcu_irq),
    .mcu_overrun(mcu_overrun), .mcu_wr(mcu_wr), .mcu_wdata(mcu_wdata)
  );

  task automatic check(input string tag, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, actual, expected);
    end
  endtask

  task automatic host_write(input int a, input int d, input int low);
    @(negedge clk);
    host_addr  = 4'(a);
    host_wdata = 8'(d);
    host_wr_n  = 1'b0;
    repeat (low) @(negedge clk);
    host_wr_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  // Returns the byte seen on host_rdata while the read strobe is low.
  task automatic host_read(output int seen);
    @(negedge clk);
    host_rd_n = 1'b0;
    repeat (3) @(negedge clk);
    seen = int'(host_rdata);
    host_rd_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic mcu_take();
    @(negedge clk); mcu_rd = 1'b1;
    @(negedge clk); mcu_rd = 1'b0;
  endtask

  task automatic mcu_put(input int d);
    @(negedge clk); mcu_wr = 1'b1; mcu_wdata = 8'(d);
    @(negedge clk); mcu_wr = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 mcu_irq in reset", int'(mcu_irq), 0);
    check("R1 host_irq in reset", int'(host_irq), 0);
    check("R1 overrun in reset", int'(mcu_overrun), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 mcu_irq after reset", int'(mcu_irq), 0);
    check("R1 host_irq after reset", int'(host_irq), 0);
    check("R1 overrun after reset", int'(mcu_overrun), 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    int seen;
    do_reset();

    // R2/R4: sweep every index, with varied strobe widths
    for (int a = 0; a < 16; a++) begin
      int d = (a * 37 + 5) & 8'hFF;
      host_write(a, d, 3 + (a % 6));
      check("R2 word", int'(mcu_word), (a << 8) | d);
      check("R2 mcu_irq", int'(mcu_irq), 1);
      mcu_take();
      check("R4 mcu_irq cleared", int'(mcu_irq), 0);
    end

    // R2: long strobe stores a single word
    host_write(9, 8'h3C, 20);
    check("R2 long strobe word", int'(mcu_word), 12'h93C);
    mcu_take();
    check("R2 long strobe once", int'(mcu_irq), 0);

    // R4: read while empty has no effect
    mcu_take();
    check("R4 empty rd irq", int'(mcu_irq), 0);
    host_write(4, 8'hA1, 4);
    check("R4 after empty rd word", int'(mcu_word), 12'h4A1);
    mcu_take();
    check("R4 no phantom word", int'(mcu_irq), 0);

    // R3: double buffering, several pairs
    for (int p = 0; p < 4; p++) begin
      int a0 = (p * 5) & 15;
      int a1 = (p * 3 + 7) & 15;
      int d0 = (p * 91 + 17) & 8'hFF;
      int d1 = (p * 29 + 200) & 8'hFF;
      host_write(a0, d0, 3);
      host_write(a1, d1, 4);
      check("R3 first word", int'(mcu_word), (a0 << 8) | d0);
      mcu_take();
      check("R3 irq held", int'(mcu_irq), 1);
      check("R3 second word", int'(mcu_word), (a1 << 8) | d1);
      mcu_take();
      check("R3 drained", int'(mcu_irq), 0);
    end
    check("R5 no overrun yet", int'(mcu_overrun), 0);

    // R6/R7: single outbound bytes
    for (int k = 0; k < 8; k++) begin
      int d = (k * 53 + 11) & 8'hFF;
      mcu_put(d);
      check("R6 host_irq", int'(host_irq), 1);
      check("R6 host_rdata", int'(host_rdata), d);
      host_read(seen);
      check("R7 byte during read", seen, d);
      check("R7 host_irq cleared", int'(host_irq), 0);
    end

    // R8: two held, third dropped
    mcu_put(8'h11);
    mcu_put(8'h22);
    mcu_put(8'h33);
    host_read(seen);
    check("R8 first byte", seen, 8'h11);
    check("R8 irq still set", int'(host_irq), 1);
    host_read(seen);
    check("R8 second byte", seen, 8'h22);
    check("R8 irq cleared", int'(host_irq), 0);

    // R9: read while empty
    host_read(seen);
    check("R9 irq stays low", int'(host_irq), 0);
    mcu_put(8'h5E);
    host_read(seen);
    check("R9 later byte intact", seen, 8'h5E);
    check("R9 irq cleared", int'(host_irq), 0);

    // R5: overrun
    host_write(1, 8'hAA, 3);
    host_write(2, 8'hBB, 3);
    check("R5 no overrun when full", int'(mcu_overrun), 0);
    host_write(3, 8'hCC, 3);
    check("R5 overrun set", int'(mcu_overrun), 1);
    check("R5 head kept", int'(mcu_word), 12'h1AA);
    mcu_take();
    check("R5 tail kept", int'(mcu_word), 12'h2BB);
    mcu_take();
    check("R5 dropped word absent", int'(mcu_irq), 0);
    check("R5 overrun sticky", int'(mcu_overrun), 1);

    // R1: reset clears pending state
    host_write(6, 8'h66, 3);
    mcu_put(8'h77);
    do_reset();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule